// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcut Summary Word

This block gathers 64 level-sensitive peripheral interrupt lines, split into two 32-line banks, and 8 local lines into one IRQ output. Each line has an enable bit. Software sets enable bits through one register per bank and clears them through a second register. Each bank has a masked pending register, which is read-only. When a device drops its line, the pending bit drops with it, because the block stores no interrupt state.

A combined status word lets software find the source of an interrupt quickly. This word holds the 8 masked local lines, one "anything pending" flag per peripheral bank, and direct copies of eleven chosen peripheral lines. A dispatcher can often resolve the vector from this single read. Vector numbers map to banks as follows: vectors 0 to 31 are bank 0, vectors 32 to 63 are bank 1, and the local lines come after those. The bank is the vector shifted right by five, and the bit is the low five bits of the vector. An 8-bit fast-interrupt control register is held and can be read back.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all enable bits and the fast-interrupt control register are 0, every mapped register reads 0, and irq_o is 0, even with all raw lines high.
- R2: A write to an enable register (0x10 bank 0, 0x14 bank 1, 0x18 local) sets each enable bit written as 1 on the next clock edge. Bits written as 0 keep their value.
- R3: A write to a disable register (0x1C bank 0, 0x20 bank 1, 0x24 local) clears each enable bit written as 1 on the next clock edge. Bits written as 0 keep their value.
- R4: Offsets 0x04 and 0x08 read the raw lines of bank 0 (lines 0-31) and bank 1 (lines 32-63) ANDed with their enable bits. Line n appears at bit n mod 32.
- R5: Bits 7:0 of the status word at offset 0x00 are the local lines ANDed with the local enable bits.
- R6: Status bit 8 is 1 when any enabled line of bank 0 is high. Status bit 9 is 1 when any enabled line of bank 1 is high.
- R7: Status bits 10 to 20 are the masked pending values of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Status bits 31:21 read 0.
- R8: irq_o is 1 exactly when at least one enabled line, peripheral or local, is high.
- R9: Offset 0x0C stores the low 8 bits of a write and reads them back with bits 31:8 as 0.
- R10: Reading an enable or disable offset returns that bank's current enable bits. Writes to the three pending offsets change no state.
- R11: Unmapped offsets and addresses with bits 1:0 not zero read 0, and writes to them change no state.
- R12: Writing all ones to the three disable registers and 0 to the fast-interrupt control register leaves every line disabled, irq_o low and the control register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| periph_irq | input | 64 | Raw peripheral lines, bit n is line n |
| local_irq | input | 8 | Raw local lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An enable, disable or control write changes state on the rising edge where bus_wr is sampled high. Read data and irq_o have no register on their path: they follow bus_addr, the raw lines and the enable state with zero cycles of latency. The bench therefore applies every stimulus on a falling edge. A read result and irq_o are sampled 1 ns after the inputs change. A value that depends on a write is only read from the falling edge that follows the write's rising edge.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;
    localparam int ADDR_W    = 6;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int BUS_W     = 32;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int LINES     = NUM_BANKS * BANK_W;
    localparam int BASIC_W   = 8;
    localparam int FIQ_W     = 8;
    localparam int NUM_SC    = 11;
    localparam int SUM_LSB   = BASIC_W;
    localparam int SC_LSB    = SUM_LSB + NUM_BANKS;

    // word index = byte address >> 2
    typedef enum logic [IDX_W-1:0] {
        REG_STATUS = 4'd0,
        REG_PEND0  = 4'd1,
        REG_PEND1  = 4'd2,
        REG_FIQ    = 4'd3,
        REG_EN0    = 4'd4,
        REG_EN1    = 4'd5,
        REG_ENL    = 4'd6,
        REG_DIS0   = 4'd7,
        REG_DIS1   = 4'd8,
        REG_DISL   = 4'd9
    } reg_idx_e;

    // peripheral line mirrored into status bit SC_LSB + k
    function automatic int sc_line(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            10:      return 62;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) st_d.en = st_q.en | wdata;
        if (clr_we) st_d.en = st_d.en & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] en,
    output logic [W-1:0] pend,
    output logic         any
);
    assign pend = raw & en;
    assign any  = |pend;
endmodule

// File: rtl/irq_status_word.sv
`timescale 1ns/1ps
module irq_status_word
    import irq_bank_pkg::*;
(
    input  logic [BASIC_W-1:0]   local_pend,
    input  logic [NUM_BANKS-1:0] bank_any,
    input  logic [NUM_SC-1:0]    sc_pend,
    output logic [BUS_W-1:0]     word
);
    localparam int USED = SC_LSB + NUM_SC;
    logic [USED-1:0] packed_bits;

    assign packed_bits = {sc_pend, bank_any, local_pend};
    assign word        = BUS_W'(packed_bits);
endmodule

// File: rtl/irq_bank_ctrl.sv
`timescale 1ns/1ps
module irq_bank_ctrl
    import irq_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [LINES-1:0]  periph_irq,
    input  logic [BASIC_W-1:0] local_irq,
    output logic              irq_o
);
    typedef struct packed {
        logic [FIQ_W-1:0] fiq;
    } ctl_t;

    logic                                aligned;
    logic                                wr_hit;
    reg_idx_e                            widx;
    logic [NUM_BANKS-1:0]                set_bank, clr_bank;
    logic [NUM_BANKS-1:0][BANK_W-1:0]    en_bank;
    logic [NUM_BANKS-1:0][BANK_W-1:0]    pend_bank;
    logic [NUM_BANKS-1:0]                any_bank;
    logic [BASIC_W-1:0]                  en_local, pend_local;
    logic                                any_local;
    logic [NUM_SC-1:0]                   sc_pend;
    logic [BUS_W-1:0]                    status_word;
    ctl_t                                ctl_d, ctl_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_wr && aligned;
    assign widx    = reg_idx_e'(bus_addr[ADDR_W-1:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign set_bank[b] = wr_hit &&
            (bus_addr[ADDR_W-1:2] == IDX_W'(int'(REG_EN0) + b));
        assign clr_bank[b] = wr_hit &&
            (bus_addr[ADDR_W-1:2] == IDX_W'(int'(REG_DIS0) + b));

        irq_enable_reg #(.W(BANK_W)) u_en (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_bank[b]),
            .clr_we (clr_bank[b]),
            .wdata  (bus_wdata[BANK_W-1:0]),
            .en_o   (en_bank[b])
        );

        irq_mask_bank #(.W(BANK_W)) u_mask (
            .raw  (periph_irq[b*BANK_W +: BANK_W]),
            .en   (en_bank[b]),
            .pend (pend_bank[b]),
            .any  (any_bank[b])
        );
    end

    irq_enable_reg #(.W(BASIC_W)) u_en_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit && widx == REG_ENL),
        .clr_we (wr_hit && widx == REG_DISL),
        .wdata  (bus_wdata[BASIC_W-1:0]),
        .en_o   (en_local)
    );

    irq_mask_bank #(.W(BASIC_W)) u_mask_local (
        .raw  (local_irq),
        .en   (en_local),
        .pend (pend_local),
        .any  (any_local)
    );

    for (genvar k = 0; k < NUM_SC; k++) begin : g_sc
        localparam int LN = sc_line(k);
        assign sc_pend[k] = pend_bank[LN / BANK_W][LN % BANK_W];
    end

    irq_status_word u_status (
        .local_pend (pend_local),
        .bank_any   (any_bank),
        .sc_pend    (sc_pend),
        .word       (status_word)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit && widx == REG_FIQ) ctl_d.fiq = bus_wdata[FIQ_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                REG_STATUS:        bus_rdata = status_word;
                REG_PEND0:         bus_rdata = pend_bank[0];
                REG_PEND1:         bus_rdata = pend_bank[1];
                REG_FIQ:           bus_rdata = BUS_W'(ctl_q.fiq);
                REG_EN0, REG_DIS0: bus_rdata = en_bank[0];
                REG_EN1, REG_DIS1: bus_rdata = en_bank[1];
                REG_ENL, REG_DISL: bus_rdata = BUS_W'(en_local);
                default:           bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = (|any_bank) | any_local;
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
`timescale 1ns/1ps
module irq_bank_ctrl_chk
    import irq_bank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq_o,
    input logic [BANK_W-1:0] en0,
    input logic [BANK_W-1:0] en1,
    input logic [BASIC_W-1:0] enl
);
    localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(int'(REG_PEND0) * 4);
    localparam logic [ADDR_W-1:0] A_EN0   = ADDR_W'(int'(REG_EN0) * 4);
    localparam logic [ADDR_W-1:0] A_DIS0  = ADDR_W'(int'(REG_DIS0) * 4);

    // R2: bits written as 1 to the set register are on one edge later
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN0) |=> ((en0 & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: bits written as 1 to the clear register are off one edge later
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS0) |=> ((en0 & $past(bus_wdata)) == '0));

    // R10, R11: no other access alters bank 0 enables
    p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_EN0 || bus_addr == A_DIS0)) |=> $stable(en0));

    // R4: pending read never shows a disabled line
    p_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PEND0) |-> ((bus_rdata & ~en0) == '0));

    // R8: a request needs at least one enable bit
    p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((|en0) || (|en1) || (|enl)));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en0       (en_bank[0]),
    .en1       (en_bank[1]),
    .enl       (en_local)
);

// File: tb/irq_bank_ctrl_tb.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] periph_irq = '0;
    logic [7:0]  local_irq = '0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_bank_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .periph_irq (periph_irq),
        .local_irq  (local_irq),
        .irq_o      (irq_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [63:0] periph;
        logic [7:0]  loc;
        logic [31:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{"R2",  1'b1, 6'h10, 32'h0000_0681, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R2",  1'b0, 6'h10, 32'h0, 64'h0, 8'h00, 32'h0000_0681, 1'b0},
        '{"R3",  1'b1, 6'h1C, 32'h0000_0001, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R3",  1'b0, 6'h1C, 32'h0, 64'h0, 8'h00, 32'h0000_0680, 1'b0},
        '{"R4",  1'b0, 6'h04, 32'h0, 64'h0000_0000_0000_0685, 8'h00, 32'h0000_0680, 1'b1},
        '{"R7",  1'b0, 6'h00, 32'h0, 64'h0000_0000_0000_0685, 8'h00, 32'h0000_1D00, 1'b1},
        '{"R2",  1'b1, 6'h14, 32'h4020_0001, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R4",  1'b0, 6'h08, 32'h0, 64'hFFFF_FFFF_0000_0000, 8'h00, 32'h4020_0001, 1'b1},
        '{"R6",  1'b0, 6'h00, 32'h0, 64'hFFFF_FFFF_0000_0000, 8'h00, 32'h0010_8200, 1'b1},
        '{"R2",  1'b1, 6'h18, 32'h0000_0081, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R5",  1'b0, 6'h00, 32'h0, 64'h0, 8'hFF, 32'h0000_0081, 1'b1},
        '{"R10", 1'b0, 6'h18, 32'h0, 64'h0, 8'hFF, 32'h0000_0081, 1'b1},
        '{"R3",  1'b1, 6'h24, 32'hFFFF_FFFF, 64'h0, 8'hFF, 32'h0, 1'b0},
        '{"R8",  1'b0, 6'h00, 32'h0, 64'h0, 8'hFF, 32'h0, 1'b0},
        '{"R10", 1'b1, 6'h04, 32'hFFFF_FFFF, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R10", 1'b0, 6'h10, 32'h0, 64'h0, 8'h00, 32'h0000_0680, 1'b0},
        '{"R9",  1'b1, 6'h0C, 32'hFFFF_FFFF, 64'h0, 8'h00, 32'h0, 1'b0},
        '{"R9",  1'b0, 6'h0C, 32'h0, 64'h0, 8'h00, 32'h0000_00FF, 1'b0},
        '{"R11", 1'b0, 6'h28, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b1},
        '{"R12", 1'b1, 6'h1C, 32'hFFFF_FFFF, {64{1'b1}}, 8'hFF, 32'h0, 1'b1},
        '{"R12", 1'b1, 6'h20, 32'hFFFF_FFFF, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b1, 6'h24, 32'hFFFF_FFFF, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b1, 6'h0C, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b0, 6'h04, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b0, 6'h0C, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b0, 6'h14, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b0},
        '{"R12", 1'b0, 6'h00, 32'h0, {64{1'b1}}, 8'hFF, 32'h0, 1'b0}
    };

    task automatic check(input logic [23:0] tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] tag, input logic [5:0] a,
                           input logic [31:0] exp, input logic exp_irq);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(tag, "rdata", bus_rdata, exp);
        check(tag, "irq_o", {31'b0, irq_o}, {31'b0, exp_irq});
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with every raw line high
        periph_irq = {64{1'b1}};
        local_irq  = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) do_read("R1", 6'(i * 4), 32'h0, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            periph_irq = VEC[i].periph;
            local_irq  = VEC[i].loc;
            bus_addr   = VEC[i].addr;
            bus_wdata  = VEC[i].data;
            bus_wr     = VEC[i].wr;
            if (!VEC[i].wr) begin
                #1;
                check(VEC[i].tag, "rdata", bus_rdata, VEC[i].exp);
                check(VEC[i].tag, "irq_o", {31'b0, irq_o}, {31'b0, VEC[i].exp_irq});
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;

        // R6, R8: bank 1 line 63 alone, not a mirrored line
        periph_irq = 64'h8000_0000_0000_0000;
        local_irq  = 8'h00;
        do_write(6'h14, 32'h8000_0000);
        do_read("R6", 6'h00, 32'h0000_0200, 1'b1);
        periph_irq = 64'h0;
        do_read("R8", 6'h08, 32'h0, 1'b0);

        // R2: writing zeros to a set register keeps state
        do_write(6'h14, 32'h0);
        do_read("R2", 6'h14, 32'h8000_0000, 1'b0);

        // R11: unaligned accesses
        do_read("R11", 6'h15, 32'h0, 1'b0);
        do_write(6'h11, 32'hFFFF_FFFF);
        do_read("R11", 6'h10, 32'h0, 1'b0);

        // R1: reset in mid run clears enables
        do_write(6'h10, 32'hFFFF_FFFF);
        do_read("R2", 6'h10, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        periph_irq = {64{1'b1}};
        do_read("R1", 6'h10, 32'h0, 1'b0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule